// File: doc/BRIEF.md
# Biphase Mark Line Codec

This block turns a serial bit stream into a biphase mark line signal and recovers bits and a bit clock from such a line. On the transmit side, the line changes level at the start of every bit period. It changes once more at the middle of the bit when the bit is a 1. The line is formed as the XOR of two toggling registers. One register flips once per bit and acts as the bit clock divided by two. The other flips at mid-bit only for a 1. The encoder makes its own bit clock from the system clock, and the sender presents each bit before that bit period starts.

On the receive side, the line passes through a synchronizer. The first line edge seen while hunting is taken as a bit start. A bit timer then samples the line at six eighths of every bit. Two equal samples in consecutive bits mean a 1, and two differing samples mean a 0. The timer restarts on each edge that falls within one eighth of a bit of the expected boundary. Edges elsewhere, such as the mid-bit edge, are ignored. A recovered clock is high for the first half of each bit, so the decoded bit changes only while that clock is low. `CLKS_PER_BIT` sets the bit length in system clocks and `SYNC_STAGES` sets the synchronizer depth. Framing above the bit level is left to the user.

Top module: `bmc_codec`

## Requirements
- R1: With `enc_en` high, `enc_line` toggles on every edge that starts a bit. `enc_bclk` is high for the first `CLKS_PER_BIT/2` clocks of each bit and low for the rest.
- R2: `enc_line` toggles a second time on the edge where `enc_bclk` falls, and only if `enc_data` was 1 on the edge just before it. `enc_line` changes on no other edge.
- R3: With `enc_en` low, `enc_line` holds its level and `enc_bclk` is 0. When `enc_en` rises, the next edge starts a new bit.
- R4: Each decoded bit is the XNOR of the line samples taken at clock `6*CLKS_PER_BIT/8` of two consecutive bits. The result is 1 when the samples are equal. `dec_valid` pulses for exactly one clock with each new `dec_data`, and `dec_data` changes only with such a pulse.
- R5: After the decoder acquires the line, the first bit yields no `dec_valid`. A burst of N bits therefore yields N-1 valid bits, which equal bits 1 to N-1 of the burst.
- R6: `dec_bclk` rises `SYNC_STAGES+1` clocks after the line edge that starts a bit, and stays high for `CLKS_PER_BIT/2` clocks. `dec_valid` occurs only while `dec_bclk` is low. `dec_data` is stable on the falling edge of `dec_bclk`.
- R7: A line edge arriving from `CLKS_PER_BIT/8` clocks before to `CLKS_PER_BIT/8` clocks after the expected bit boundary restarts the bit timer. Edges outside that window do not restart the timer. Bit periods that vary by up to `CLKS_PER_BIT/8 - 1` clocks decode correctly.
- R8: If no boundary edge arrives within `CLKS_PER_BIT + CLKS_PER_BIT/8` clocks of the last bit start, the decoder returns to hunting. While hunting, `dec_bclk` is 0 and no `dec_valid` occurs. The next edge starts a fresh acquisition.
- R9: During reset, `enc_line`, `enc_bclk`, `dec_bclk`, `dec_data` and `dec_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_en | input | 1 | Encoder run enable |
| enc_data | input | 1 | Bit to encode, sampled just before mid-bit |
| enc_line | output | 1 | Encoded biphase mark line |
| enc_bclk | output | 1 | Encoder bit clock, high in first half of each bit |
| dec_line | input | 1 | Incoming biphase mark line (asynchronous) |
| dec_bclk | output | 1 | Recovered bit clock, rises at each bit start |
| dec_data | output | 1 | Last decoded bit |
| dec_valid | output | 1 | One-clock strobe marking a new decoded bit |

## Verification
On every cycle, the assertions check several local rules. The encoder line may change only where its bit clock changes, and it must toggle at each bit start. The line stays frozen while the encoder is disabled. The decoder's strobe lasts one clock and falls inside the low phase, and the decoded bit is steady at the recovered clock's fall. The bit timer never passes its loss-of-lock limit, and no strobe is issued while hunting. Only the bench's scenarios can show the following: that recovered bits match what was sent, that the first bit after acquisition is dropped, that the recovered clock trails the transmit clock by the synchronizer latency, that jittered bit periods still decode, and that a silent line returns the decoder to hunting.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

   typedef enum logic {
      DEC_HUNT  = 1'b0,
      DEC_TRACK = 1'b1
   } dec_mode_t;

endpackage

// File: rtl/bmc_encoder.sv
module bmc_encoder #(
   parameter int CLKS_PER_BIT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic data_i,
   output logic line_o,
   output logic bclk_o
);
   localparam int HALF = CLKS_PER_BIT / 2;
   localparam int CW   = $clog2(CLKS_PER_BIT);
   localparam logic [CW-1:0] LAST_C  = CW'(CLKS_PER_BIT - 1);
   localparam logic [CW-1:0] PREMID_C = CW'(HALF - 1);
   localparam logic [CW-1:0] HALF_C  = CW'(HALF);

   logic [CW-1:0] phase_q;
   logic          mid_tgl_q;
   logic          div2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= LAST_C;
         mid_tgl_q <= 1'b0;
         div2_q    <= 1'b0;
      end else if (en_i) begin
         if (phase_q == LAST_C) begin
            phase_q <= '0;
            div2_q  <= ~div2_q;
         end else begin
            phase_q <= phase_q + CW'(1);
         end
         if (phase_q == PREMID_C) begin
            mid_tgl_q <= mid_tgl_q ^ data_i;
         end
      end else begin
         phase_q <= LAST_C;
      end
   end

   assign line_o = mid_tgl_q ^ div2_q;
   assign bclk_o = (phase_q < HALF_C);

endmodule

// File: rtl/bmc_line_sync.sv
module bmc_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= d_i;
         end
         assign q_o = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[STAGES-2:0], d_i};
         end
         assign q_o = s_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bmc_decoder.sv
module bmc_decoder
   import bmc_pkg::*;
#(
   parameter int CLKS_PER_BIT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic bclk_o,
   output logic data_o,
   output logic valid_o,
   output logic track_o
);
   localparam int EIGHTH = CLKS_PER_BIT / 8;
   localparam int HALF   = CLKS_PER_BIT / 2;
   localparam int SAMPLE = 6 * EIGHTH;
   localparam int LIMIT  = CLKS_PER_BIT + EIGHTH;
   localparam int DW     = $clog2(LIMIT + 1);
   localparam logic [DW-1:0] WIN_LO_C = DW'(CLKS_PER_BIT - EIGHTH);
   localparam logic [DW-1:0] LIMIT_C  = DW'(LIMIT);
   localparam logic [DW-1:0] SAMP_C   = DW'(SAMPLE);
   localparam logic [DW-1:0] HALF_C   = DW'(HALF);

   dec_mode_t     mode_q;
   logic [DW-1:0] cnt_q;
   logic          line_q;
   logic          samp_q;
   logic          have_prev_q;
   logic          data_q;
   logic          valid_q;
   logic          edge_seen;

   assign edge_seen = line_i ^ line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= DEC_HUNT;
         cnt_q       <= '0;
         line_q      <= 1'b0;
         samp_q      <= 1'b0;
         have_prev_q <= 1'b0;
         data_q      <= 1'b0;
         valid_q     <= 1'b0;
      end else begin
         line_q  <= line_i;
         valid_q <= 1'b0;
         case (mode_q)
            DEC_HUNT: begin
               if (edge_seen) begin
                  mode_q      <= DEC_TRACK;
                  cnt_q       <= '0;
                  have_prev_q <= 1'b0;
               end
            end
            DEC_TRACK: begin
               if (edge_seen && (cnt_q >= WIN_LO_C)) begin
                  cnt_q <= '0;
               end else if (cnt_q == LIMIT_C) begin
                  mode_q      <= DEC_HUNT;
                  cnt_q       <= '0;
                  have_prev_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + DW'(1);
               end
               if (cnt_q == SAMP_C) begin
                  samp_q      <= line_i;
                  have_prev_q <= 1'b1;
                  if (have_prev_q) begin
                     data_q  <= ~(samp_q ^ line_i);
                     valid_q <= 1'b1;
                  end
               end
            end
            default: mode_q <= DEC_HUNT;
         endcase
      end
   end

   assign track_o = (mode_q == DEC_TRACK);
   assign bclk_o  = track_o && (cnt_q < HALF_C);
   assign data_o  = data_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/bmc_codec.sv
module bmc_codec #(
   parameter int CLKS_PER_BIT = 32,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enc_en,
   input  logic enc_data,
   output logic enc_line,
   output logic enc_bclk,
   input  logic dec_line,
   output logic dec_bclk,
   output logic dec_data,
   output logic dec_valid
);
   if ((CLKS_PER_BIT < 16) || ((CLKS_PER_BIT % 8) != 0)) begin : g_bad_len
      initial $fatal(1, "CLKS_PER_BIT must be a multiple of 8 and at least 16");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      initial $fatal(1, "SYNC_STAGES must be at least 1");
   end

   logic line_s;
   logic dec_track;

   bmc_encoder #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_enc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (enc_en),
      .data_i (enc_data),
      .line_o (enc_line),
      .bclk_o (enc_bclk)
   );

   bmc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (dec_line),
      .q_o   (line_s)
   );

   bmc_decoder #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line_s),
      .bclk_o  (dec_bclk),
      .data_o  (dec_data),
      .valid_o (dec_valid),
      .track_o (dec_track)
   );

endmodule

// File: rtl/bmc_codec_chk.sv
module bmc_codec_chk #(
   parameter int CLKS_PER_BIT = 32
) (
   input logic clk,
   input logic rst_n,
   input logic enc_en,
   input logic enc_line,
   input logic enc_bclk,
   input logic dec_bclk,
   input logic dec_data,
   input logic dec_valid,
   input logic dec_track,
   input logic [$clog2(CLKS_PER_BIT + CLKS_PER_BIT/8 + 1)-1:0] dec_cnt
);
   localparam int LIMIT = CLKS_PER_BIT + CLKS_PER_BIT / 8;

   AST_START_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enc_bclk) |-> (enc_line != $past(enc_line)));                  // R1

   AST_LINE_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_line != $past(enc_line)) |-> (enc_bclk != $past(enc_bclk)));    // R2

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_en |=> ($stable(enc_line) && !enc_bclk));                       // R3

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);                                           // R4

   AST_DATA_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_data != $past(dec_data)) |-> dec_valid);                        // R4

   AST_VALID_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> !dec_bclk);                                            // R6

   AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dec_bclk) |-> $stable(dec_data));                              // R6

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      dec_track |-> (int'(dec_cnt) <= LIMIT));                             // R8

   AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_track |-> (!dec_valid && !dec_bclk));                           // R8

endmodule

bind bmc_codec bmc_codec_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enc_en    (enc_en),
   .enc_line  (enc_line),
   .enc_bclk  (enc_bclk),
   .dec_bclk  (dec_bclk),
   .dec_data  (dec_data),
   .dec_valid (dec_valid),
   .dec_track (dec_track),
   .dec_cnt   (u_dec.cnt_q)
);

// File: tb/bmc_codec_bench.sv
`timescale 1ns/1ps
module bmc_codec_bench;
   localparam int CPB  = 32;
   localparam int HALF = CPB / 2;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enc_en = 1'b0;
   logic enc_data = 1'b0;
   logic drv_line = 1'b0;
   logic loop_sel = 1'b1;
   logic loop_chk = 1'b0;
   logic enc_line, enc_bclk, dec_line, dec_bclk, dec_data, dec_valid;

   assign dec_line = loop_sel ? enc_line : drv_line;

   always #4 clk = ~clk;

   bmc_codec #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(SYNC)) u_bmc_codec (
      .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .enc_data(enc_data),
      .enc_line(enc_line), .enc_bclk(enc_bclk), .dec_line(dec_line),
      .dec_bclk(dec_bclk), .dec_data(dec_data), .dec_valid(dec_valid)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   int  valid_cnt = 0;
   bit  exp_q[$];
   bit  bits[64];

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural transmit model, advanced on each rising edge
   int m_ph = -1;
   int m_line = 0;
   int m_bclk = 0;
   int hist[8];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = -1;
         m_line = 0;
      end else if (enc_en) begin
         if (m_ph < 0 || m_ph == CPB - 1) begin
            m_ph = 0;
            m_line = 1 - m_line;
         end else begin
            if (m_ph == HALF - 1 && enc_data) m_line = 1 - m_line;
            m_ph++;
         end
      end else begin
         m_ph = -1;
      end
      m_bclk = (m_ph >= 0 && m_ph < HALF) ? 1 : 0;
      for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = m_bclk;
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 R2 R3 enc_line", int'(enc_line), m_line);
         check("R1 R3 enc_bclk", int'(enc_bclk), m_bclk);
         if (loop_chk) check("R6 dec_bclk timing", int'(dec_bclk), hist[LAT]);
         if (dec_valid) begin
            valid_cnt++;
            if (exp_q.size() == 0) check("R5 R8 unexpected dec_valid", 1, 0);
            else check("R4 dec_data", int'(dec_data), int'(exp_q.pop_front()));
         end
      end
   end

   function automatic bit pick(input int kind, input int k);
      case (kind)
         1: return 1'b1;
         2: return 1'b0;
         3: return 1'(((k * 11 + 2) % 5) < 2);
         default: return 1'(((k * 13 + 5) % 7) < 3);
      endcase
   endfunction

   task automatic load_bits(input int n, input int kind);
      for (int k = 0; k < n; k++) bits[k] = pick(kind, k);
      for (int k = 1; k < n; k++) exp_q.push_back(bits[k]);
      valid_cnt = 0;
   endtask

   task automatic end_burst(input int n);
      repeat (3 * CPB) @(negedge clk);
      check("R5 valid count", valid_cnt, n - 1);
      check("R5 queue drained", exp_q.size(), 0);
      check("R8 dec_bclk after silence", int'(dec_bclk), 0);
   endtask

   task automatic enc_burst(input int n, input int kind);
      load_bits(n, kind);
      @(negedge clk);
      enc_en = 1'b1;
      for (int k = 0; k < n; k++) begin
         enc_data = bits[k];
         repeat (CPB) @(negedge clk);
      end
      enc_en = 1'b0;
      end_burst(n);
   endtask

   task automatic jitter_burst(input int n, input int kind);
      load_bits(n, kind);
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         int len;
         len = CPB + ((k * 5) % 7) - 3;   // R7: periods vary by up to 3 clocks
         drv_line = ~drv_line;
         if (bits[k]) begin
            repeat (HALF) @(negedge clk);
            drv_line = ~drv_line;
            repeat (len - HALF) @(negedge clk);
         end else begin
            repeat (len) @(negedge clk);
         end
      end
      end_burst(n);
      for (int i = 0; i < 2 * CPB; i++) begin
         @(negedge clk);
         if (dec_bclk) check("R8 hunting keeps dec_bclk low", 1, 0);
      end
      check("R7 R8 jitter burst complete", valid_cnt, n - 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (5) @(negedge clk);
      check("R9 enc_line reset", int'(enc_line), 0);
      check("R9 enc_bclk reset", int'(enc_bclk), 0);
      check("R9 dec_bclk reset", int'(dec_bclk), 0);
      check("R9 dec_data reset", int'(dec_data), 0);
      check("R9 dec_valid reset", int'(dec_valid), 0);
      rst_n = 1'b1;
      loop_chk = 1'b1;
      repeat (2 * CPB) @(negedge clk);
      enc_burst(24, 0);
      enc_burst(12, 1);
      enc_burst(12, 2);
      enc_burst(9, 3);
      loop_chk = 1'b0;
      drv_line = enc_line;
      @(negedge clk);
      loop_sel = 1'b0;
      repeat (4) @(negedge clk);
      jitter_burst(20, 3);
      jitter_burst(16, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule